// File: doc/BRIEF.md
# Audio Link Record-Frame Serializer

This block is the codec-side transmitter of the serial input stream on an AC'97-style audio link. The controller marks each frame by raising SYNC, which changes on the rising edge of the bit clock. The serializer samples SYNC on the falling edge. When it sees a low-to-high change, it takes a snapshot of its inputs: the codec-ready flag, the status response (register index, slot-request bits and read data, with their valid flags) and the left record sample with its valid flag. From the next rising edge it shifts out a 256-bit frame, MSB first.

The frame opens with a 16-bit tag slot and continues with twelve 20-bit slots. Slot 1 echoes the register index together with the slot-request bits. Slot 2 carries the register read data. Slot 3 carries the left record sample. Every reserved field, every invalid slot and slots 4 to 12 are sent as zeros. The sample width is a parameter of at most 20 bits. The sample is placed at the top of its slot and the unused low bits are zero.

Top module: `ac_link_in_ser`

## Requirements
- R1: While reset is asserted, and from reset until the first SYNC rise has been sampled, `sdata_in` is 0.
- R2: SYNC is sampled on the falling edge of `bit_clk`. A low-to-high change seen there makes the next rising edge drive frame bit 0, which is the codec-ready value. Before that rising edge the output keeps its previous value.
- R3: Frame bits 0 to 255 are driven on 256 consecutive rising edges, one bit per edge, MSB of each slot first. After bit 255, `sdata_in` is 0 until the next SYNC rise.
- R4: Tag slot (frame bits 0–15, tag bit 15 first): bit 15 = codec ready, bit 14 = slot 1 valid (`stat_idx_vld`), bit 13 = slot 2 valid (`stat_data_vld`), bit 12 = slot 3 valid (`rec_left_vld`), bits 11:0 = 0.
- R5: When slot 1 is valid (frame bits 16–35), its bit 19 = 0, bits 18:12 = `stat_idx`, bits 11:2 = `slot_req` and bits 1:0 = 0.
- R6: When slot 2 is valid (frame bits 36–55), its bits 19:4 = `stat_data` and bits 3:0 = 0.
- R7: When slot 3 is valid (frame bits 56–75), `rec_left` fills bits 19 down to 20−SAMPLE_W. The bits below are 0.
- R8: Each slot tagged invalid is sent as twenty zeros. Slots 4 to 12 (frame bits 76–255) are always zero.
- R9: All inputs are captured on the rising edge that drives bit 0. Changes after that edge do not alter the frame in progress.
- R10: A new SYNC rise sampled during a frame abandons that frame. A new frame starts with bit 0 on the following rising edge.
- R11: Holding SYNC high across many bits does not restart the frame. Only a low-to-high change starts a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Frame marker from the controller |
| codec_ready | input | 1 | Codec-ready flag for the tag slot |
| stat_idx_vld | input | 1 | Slot 1 (index echo) valid |
| stat_idx | input | 7 | Register index echoed in slot 1 |
| slot_req | input | 10 | Slot-request bits in slot 1 |
| stat_data_vld | input | 1 | Slot 2 (read data) valid |
| stat_data | input | 16 | Register read data for slot 2 |
| rec_left_vld | input | 1 | Slot 3 (left sample) valid |
| rec_left | input | SAMPLE_W | Left record sample |
| sdata_in | output | 1 | Serial frame output |

## Verification
The bound checker watches every rising edge for the following:
- the codec-ready bit following each sampled SYNC rise;
- the bit counter stepping by one;
- restart on a new SYNC rise;
- zeros whenever no frame is active;
- zeros at fixed reserved positions: tag bits 11:0, the slot 1 MSB and trailing bits, the slot 2 trailing bits, the slot 3 padding and slots 4 to 12.

Only the bench scenarios can show the following, because each needs the full frame compared against a snapshot of the inputs:
- that payload fields land in the right bit positions;
- that invalid slots are fully zeroed;
- that input changes after the capture edge are ignored;
- that a long SYNC pulse does not restart the frame.

// File: rtl/ac_link_in_pkg.sv
package ac_link_in_pkg;
    localparam int TAG_W     = 16;
    localparam int SLOT_W    = 20;
    localparam int NUM_SLOTS = 12;
    localparam int FRAME_W   = TAG_W + SLOT_W * NUM_SLOTS;
    localparam int CNT_W     = $clog2(FRAME_W);
    localparam int IDX_W     = 7;
    localparam int REQ_W     = 10;
    localparam int RDATA_W   = 16;

    // Highest frame-vector bit of data slot n (1-based); frame bit FRAME_W-1 goes out first
    function automatic int slot_top(input int n);
        return FRAME_W - 1 - TAG_W - SLOT_W * (n - 1);
    endfunction
endpackage

// File: rtl/ac_link_sync_det.sv
module ac_link_sync_det (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic sync,
    output logic start
);
    typedef struct packed {
        logic sync_q;
        logic start;
    } det_t;

    det_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.sync_q = sync;
        st_d.start  = sync & ~st_q.sync_q;
    end

    // falling-edge sample of the frame marker
    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start = st_q.start;
endmodule

// File: rtl/ac_link_frame_build.sv
module ac_link_frame_build
    import ac_link_in_pkg::*;
#(
    parameter int SAMPLE_W = 18
) (
    input  logic                codec_ready,
    input  logic                stat_idx_vld,
    input  logic [IDX_W-1:0]    stat_idx,
    input  logic [REQ_W-1:0]    slot_req,
    input  logic                stat_data_vld,
    input  logic [RDATA_W-1:0]  stat_data,
    input  logic                rec_left_vld,
    input  logic [SAMPLE_W-1:0] rec_left,
    output logic [FRAME_W-1:0]  frame
);
    localparam int PAD_W = SLOT_W - SAMPLE_W;

    logic [TAG_W-1:0]  tag_w;
    logic [SLOT_W-1:0] s1_w, s2_w, s3_w;

    always_comb begin
        tag_w            = '0;
        tag_w[TAG_W-1]   = codec_ready;
        tag_w[TAG_W-2]   = stat_idx_vld;
        tag_w[TAG_W-3]   = stat_data_vld;
        tag_w[TAG_W-4]   = rec_left_vld;

        s1_w = '0;
        if (stat_idx_vld) begin
            s1_w[18:12] = stat_idx;
            s1_w[11:2]  = slot_req;
        end

        s2_w = '0;
        if (stat_data_vld) s2_w[19:4] = stat_data;

        s3_w = '0;
        if (rec_left_vld) s3_w = SLOT_W'(rec_left) << PAD_W;

        frame = '0;
        frame[FRAME_W-1 -: TAG_W]  = tag_w;
        frame[slot_top(1) -: SLOT_W] = s1_w;
        frame[slot_top(2) -: SLOT_W] = s2_w;
        frame[slot_top(3) -: SLOT_W] = s3_w;
    end
endmodule

// File: rtl/ac_link_frame_shift.sv
module ac_link_frame_shift
    import ac_link_in_pkg::*;
(
    input  logic               bit_clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               sdata,
    output logic               active,
    output logic [CNT_W-1:0]   cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               active;
        logic               sdata;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.sdata  = frame[FRAME_W-1];
            st_d.shreg  = {frame[FRAME_W-2:0], 1'b0};
            st_d.cnt    = '0;
            st_d.active = 1'b1;
        end else if (st_q.active) begin
            if (st_q.cnt == LAST) begin
                st_d.sdata  = 1'b0;
                st_d.active = 1'b0;
                st_d.cnt    = '0;
                st_d.shreg  = '0;
            end else begin
                st_d.sdata = st_q.shreg[FRAME_W-1];
                st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b0};
                st_d.cnt   = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.sdata = 1'b0;
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdata  = st_q.sdata;
    assign active = st_q.active;
    assign cnt    = st_q.cnt;
endmodule

// File: rtl/ac_link_in_ser.sv
module ac_link_in_ser
    import ac_link_in_pkg::*;
#(
    parameter int SAMPLE_W = 18
) (
    input  logic                bit_clk,
    input  logic                rst_n,
    input  logic                sync,
    input  logic                codec_ready,
    input  logic                stat_idx_vld,
    input  logic [6:0]          stat_idx,
    input  logic [9:0]          slot_req,
    input  logic                stat_data_vld,
    input  logic [15:0]         stat_data,
    input  logic                rec_left_vld,
    input  logic [SAMPLE_W-1:0] rec_left,
    output logic                sdata_in
);
    logic               start_w;
    logic [FRAME_W-1:0] frame_w;
    logic               active_w;
    logic [CNT_W-1:0]   cnt_w;

    ac_link_sync_det u_det (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .sync    (sync),
        .start   (start_w)
    );

    ac_link_frame_build #(.SAMPLE_W(SAMPLE_W)) u_build (
        .codec_ready   (codec_ready),
        .stat_idx_vld  (stat_idx_vld),
        .stat_idx      (stat_idx),
        .slot_req      (slot_req),
        .stat_data_vld (stat_data_vld),
        .stat_data     (stat_data),
        .rec_left_vld  (rec_left_vld),
        .rec_left      (rec_left),
        .frame         (frame_w)
    );

    ac_link_frame_shift u_shift (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .frame   (frame_w),
        .sdata   (sdata_in),
        .active  (active_w),
        .cnt     (cnt_w)
    );
endmodule

// File: rtl/ac_link_in_ser_chk.sv
module ac_link_in_ser_chk
    import ac_link_in_pkg::*;
#(
    parameter int SAMPLE_W = 18
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic             start,
    input logic             active,
    input logic [CNT_W-1:0] cnt,
    input logic             sdata,
    input logic             codec_ready
);
    localparam logic [CNT_W-1:0] LAST     = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] S1_MSB   = CNT_W'(16);
    localparam logic [CNT_W-1:0] S1_T0    = CNT_W'(34);
    localparam logic [CNT_W-1:0] S1_T1    = CNT_W'(35);
    localparam logic [CNT_W-1:0] S2_T_LO  = CNT_W'(52);
    localparam logic [CNT_W-1:0] S2_T_HI  = CNT_W'(55);
    localparam logic [CNT_W-1:0] TAG_Z_LO = CNT_W'(4);
    localparam logic [CNT_W-1:0] TAG_Z_HI = CNT_W'(15);
    localparam logic [CNT_W-1:0] TAIL_LO  = CNT_W'(76);

    p_idle_zero_r1: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !active |-> !sdata);

    p_first_bit_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        start |=> (sdata == $past(codec_ready)));

    p_bit_step_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (active && !start && cnt != LAST) |=> (active && cnt == $past(cnt) + 1'b1));

    p_tag_zero_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (active && cnt >= TAG_Z_LO && cnt <= TAG_Z_HI) |-> !sdata);

    p_slot1_pad_r5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (active && (cnt == S1_MSB || cnt == S1_T0 || cnt == S1_T1)) |-> !sdata);

    p_slot2_pad_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (active && cnt >= S2_T_LO && cnt <= S2_T_HI) |-> !sdata);

    generate
        if (SAMPLE_W < SLOT_W) begin : g_pad
            localparam logic [CNT_W-1:0] S3_PAD_LO = CNT_W'(56 + SAMPLE_W);
            p_slot3_pad_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
                (active && cnt >= S3_PAD_LO && cnt < TAIL_LO) |-> !sdata);
        end
    endgenerate

    p_unused_slots_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (active && cnt >= TAIL_LO) |-> !sdata);

    p_restart_r10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        start |=> (active && cnt == '0));
endmodule

bind ac_link_in_ser ac_link_in_ser_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (
    .bit_clk     (bit_clk),
    .rst_n       (rst_n),
    .start       (start_w),
    .active      (active_w),
    .cnt         (cnt_w),
    .sdata       (sdata_in),
    .codec_ready (codec_ready)
);

// File: tb/ac_link_in_ser_tb_top.sv
module ac_link_in_ser_tb_top;
    localparam int SW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync = 1'b0;
    logic          ready = 1'b0;
    logic          v1 = 1'b0, v2 = 1'b0, v3 = 1'b0;
    logic [6:0]    idx = '0;
    logic [9:0]    req = '0;
    logic [15:0]   rdat = '0;
    logic [SW-1:0] smp = '0;
    logic          sdo;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    ac_link_in_ser #(.SAMPLE_W(SW)) dut_i (
        .bit_clk(clk), .rst_n(rst_n), .sync(sync), .codec_ready(ready),
        .stat_idx_vld(v1), .stat_idx(idx), .slot_req(req),
        .stat_data_vld(v2), .stat_data(rdat),
        .rec_left_vld(v3), .rec_left(smp), .sdata_in(sdo)
    );

    function automatic logic [255:0] exp_frame();
        logic [15:0] t;
        logic [19:0] a, b, c;
        t = {ready, v1, v2, v3, 12'h000};
        a = v1 ? {1'b0, idx, req, 2'b00} : 20'h0;
        b = v2 ? {rdat, 4'h0} : 20'h0;
        c = v3 ? {smp, 2'b00} : 20'h0;
        return {t, a, b, c, 180'h0};
    endfunction

    function automatic string req_of(input int k);
        if (k == 0)  return "R2";
        if (k < 16)  return "R4";
        if (k < 36)  return v1 ? "R5" : "R8";
        if (k < 56)  return v2 ? "R6" : "R8";
        if (k < 76)  return v3 ? "R7" : "R8";
        return "R8";
    endfunction

    task automatic check(input logic got, input logic exp, input string rq, input int pos);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s pos %0d: got %b expected %b", rq, pos, got, exp);
        end
    endtask

    task automatic rand_inputs();
        ready = 1'($urandom);
        v1 = 1'($urandom); v2 = 1'($urandom); v3 = 1'($urandom);
        idx = 7'($urandom); req = 10'($urandom);
        rdat = 16'($urandom); smp = SW'($urandom);
    endtask

    // nbits: bits compared; slen: cycles SYNC stays high; chg: scramble inputs after capture edge
    task automatic run_frame(input int nbits, input int slen, input bit chg, input bit idle_before);
        logic [255:0] e;
        logic [255:0] tags;
        @(posedge clk); #1;
        sync = 1'b1;
        e = exp_frame();
        tags = {v1, v2, v3, 253'h0};
        @(negedge clk);
        if (idle_before) check(sdo, 1'b0, "R2", -1);
        for (int k = 0; k < nbits; k++) begin
            @(posedge clk); #1;
            if (k == slen - 1) sync = 1'b0;
            if (k == 0 && chg) rand_inputs();
            @(negedge clk);
            if (chg && k > 0) check(sdo, e[255-k], "R9", k);
            else check(sdo, e[255-k], req_of(k), k);
        end
        if (tags[255]) begin end
    endtask

    task automatic check_idle(input int n, input string rq);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(sdo, 1'b0, rq, i);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state, then no frame before first SYNC
        rand_inputs();
        ready = 1'b1; v1 = 1'b1;
        repeat (3) @(negedge clk);
        check(sdo, 1'b0, "R1", 0);
        @(posedge clk); #1 rst_n = 1'b1;
        check_idle(30, "R1");

        // directed: all valid, all ones payload (R4 R5 R6 R7)
        ready = 1'b1; v1 = 1'b1; v2 = 1'b1; v3 = 1'b1;
        idx = '1; req = '1; rdat = '1; smp = '1;
        run_frame(256, 16, 1'b0, 1'b1);
        check_idle(5, "R3");

        // directed: payload ones but every slot invalid (R8)
        ready = 1'b1; v1 = 1'b0; v2 = 1'b0; v3 = 1'b0;
        run_frame(256, 16, 1'b0, 1'b1);
        check_idle(3, "R3");

        // directed: alternating pattern, codec not ready
        ready = 1'b0; v1 = 1'b1; v2 = 1'b1; v3 = 1'b1;
        idx = 7'h55; req = 10'h2AA; rdat = 16'hA5C3; smp = 18'h2_5A3C;
        run_frame(256, 16, 1'b0, 1'b1);

        // R11: SYNC held high for 60 bits must not restart
        rand_inputs(); v1 = 1'b1; v2 = 1'b1; v3 = 1'b1;
        run_frame(256, 60, 1'b0, 1'b1);
        check_idle(4, "R3");

        // R10: abandon a frame after 100 bits, then a fresh frame
        rand_inputs(); ready = 1'b1; v2 = 1'b1;
        run_frame(100, 16, 1'b0, 1'b1);
        rand_inputs(); ready = 1'b1; v1 = 1'b1; v3 = 1'b1;
        idx = ~idx;
        run_frame(256, 16, 1'b0, 1'b0);
        check_idle(2, "R10");

        // R9 and random frames
        for (int f = 0; f < 12; f++) begin
            rand_inputs();
            run_frame(256, 16, (f % 2) == 0, 1'b1);
            check_idle(2, "R3");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule